// File: doc/BRIEF.md
# Dual Reloadable Interval Timer

This block holds two 16-bit down-counters. Each counter has its own 16-bit reload latch. Both move only on a clock-enable tick and are set up through byte-wide register accesses. The first timer can run free, reloading itself every period, or run in single-shot mode. A bit in a small control register selects which. The second timer is always single-shot and has no readable latch. Each timer drives a sticky timeout flag that goes straight out as an interrupt line. The flag is cleared as a side effect of the register accesses that restart or acknowledge the timer.

A host programs the latch one byte at a time. Writing the counter high byte commits the latch into the counter and starts a new interval. Reads return the live counter bytes, so software can poll the remaining time. Reading the counter low byte acknowledges the timeout.

Each timer has a two-state arm machine. `ST_DISARMED` is the state after reset and after a single-shot timeout. `ST_ARMED` is entered from either state on a counter-high write (transition LOAD). In single-shot mode, a tick that brings the counter to zero moves `ST_ARMED` back to `ST_DISARMED` (transition EXPIRE). In free-running mode the state has no effect on the flag.

Top module: `ivt_top`

## Requirements
- R1: In free-running mode (control bit 0 = 1) timer A counts latch, latch-1, …, 0, 0xFFFF. The tick after 0xFFFF reloads the latch value, so one period is latch+2 ticks.
- R2: A timer's flag (irq_a, irq_b) is set at the clock edge of a tick that leaves its counter at 0. It stays set until it is cleared by an access.
- R3: A write to address 0 (A counter low) or address 2 (A latch low), and a write to address 4 (B counter low), updates only the latch low byte. The counter keeps its value.
- R4: A write to address 1 (A counter high) or address 5 (B counter high) sets the latch high byte. In the same edge it loads the counter with {written byte, latch low byte}, clears that timer's flag and arms it. A tick in that cycle is discarded.
- R5: A write to address 3 (A latch high) sets the latch high byte and clears irq_a. The counter is not changed.
- R6: A read (rd_en) of address 0 or 4 returns counter bits 7:0 and clears that timer's flag. A read of address 1 or 5 returns counter bits 15:8 and leaves the flag unchanged.
- R7: Reads of addresses 2 and 3 return timer A's latch bytes, low and high. Address 6 reads 0, so timer B's latch cannot be read.
- R8: After reset both latches and both counters hold 0xFFFF, both flags are 0, the control byte is 0 (single-shot) and both timers are disarmed.
- R9: In single-shot mode (timer A with control bit 0 = 0, and timer B always) the flag is set only on the first zero after a counter-high write. The counter then keeps decrementing through 0xFFFF, 0xFFFE, … with no reload and no further flag.
- R10: When a tick that reaches zero falls in the same cycle as a flag-clearing read of address 0 or a write of address 3, the flag ends set.
- R11: Address 7 is the control byte: a write stores it and a read returns it. Only bit 0 (timer A free-running) has an effect, and timer B never reloads whatever its value.
- R12: With no tick and no counter-high write, a counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; each asserted cycle is one timer tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for `addr`, combinational |
| irq_a | output | 1 | Timeout flag of timer A |
| irq_b | output | 1 | Timeout flag of timer B |

## Verification
The delicate overlap is a tick that takes a counter to zero in the same cycle as an access that clears the flag. The bench provokes it in two ways. It counts timer A down to 1 and then, in one cycle, raises tick together with a read strobe on the counter low byte. In a second pass it raises tick together with a write of the latch high byte. In both cases irq_a is judged set afterwards. The counter-high write with tick raised is also judged: the counter must hold the freshly loaded value, not one less.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_A_CNT_LO = 3'd0,
        REG_A_CNT_HI = 3'd1,
        REG_A_LAT_LO = 3'd2,
        REG_A_LAT_HI = 3'd3,
        REG_B_CNT_LO = 3'd4,
        REG_B_CNT_HI = 3'd5,
        REG_SPARE    = 3'd6,
        REG_CTRL     = 3'd7
    } reg_sel_e;

    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } arm_state_e;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi_load;
        logic wr_hi_latch;
        logic rd_lo;
    } tmr_strobe_t;

endpackage

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter bit ONE_SHOT_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              free_mode,
    input  tmr_strobe_t       stb,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  latch,
    output logic              flag
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    arm_state_e       state_q, state_d;
    logic             free_run;
    logic [CNT_W-1:0] cnt_step;
    logic             hit;
    logic             fire;

    assign free_run = free_mode & ~ONE_SHOT_ONLY;

    // next counter value for a tick; reload happens one tick after 0xFFFF
    always_comb begin
        cnt_step = (free_run && cnt == ALL_ONES) ? latch : cnt - ONE;
        hit      = tick && !stb.wr_hi_load && (cnt_step == '0);
        fire     = hit && (free_run || state_q == ST_ARMED);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: begin
                if (stb.wr_hi_load) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (stb.wr_hi_load)          state_d = ST_ARMED;
                else if (hit && !free_run)   state_d = ST_DISARMED;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= ALL_ONES;
            latch <= ALL_ONES;
        end else begin
            if (stb.wr_lo)
                latch[BYTE_W-1:0] <= wdata;
            if (stb.wr_hi_load || stb.wr_hi_latch)
                latch[CNT_W-1:BYTE_W] <= wdata;
            if (stb.wr_hi_load)
                cnt <= {wdata, latch[BYTE_W-1:0]};
            else if (tick)
                cnt <= cnt_step;
        end
    end

    // output process: a timeout wins over a clearing access in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (fire)
            flag <= 1'b1;
        else if (stb.wr_hi_load || stb.wr_hi_latch || stb.rd_lo)
            flag <= 1'b0;
    end

endmodule

// File: rtl/ivt_regif.sv
module ivt_regif
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_a,
    input  logic [CNT_W-1:0]  latch_a,
    input  logic [CNT_W-1:0]  cnt_b,
    output tmr_strobe_t       stb_a,
    output tmr_strobe_t       stb_b,
    output logic              free_mode,
    output logic [BYTE_W-1:0] rdata
);

    reg_sel_e          sel;
    logic [BYTE_W-1:0] ctrl_q;

    assign sel       = reg_sel_e'(addr);
    assign free_mode = ctrl_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n)                        ctrl_q <= '0;
        else if (wr_en && sel == REG_CTRL) ctrl_q <= wdata;
    end

    always_comb begin
        stb_a.wr_lo       = wr_en && (sel == REG_A_CNT_LO || sel == REG_A_LAT_LO);
        stb_a.wr_hi_load  = wr_en && (sel == REG_A_CNT_HI);
        stb_a.wr_hi_latch = wr_en && (sel == REG_A_LAT_HI);
        stb_a.rd_lo       = rd_en && (sel == REG_A_CNT_LO);
        stb_b.wr_lo       = wr_en && (sel == REG_B_CNT_LO);
        stb_b.wr_hi_load  = wr_en && (sel == REG_B_CNT_HI);
        stb_b.wr_hi_latch = 1'b0;
        stb_b.rd_lo       = rd_en && (sel == REG_B_CNT_LO);
    end

    always_comb begin
        unique case (sel)
            REG_A_CNT_LO: rdata = cnt_a[BYTE_W-1:0];
            REG_A_CNT_HI: rdata = cnt_a[CNT_W-1:BYTE_W];
            REG_A_LAT_LO: rdata = latch_a[BYTE_W-1:0];
            REG_A_LAT_HI: rdata = latch_a[CNT_W-1:BYTE_W];
            REG_B_CNT_LO: rdata = cnt_b[BYTE_W-1:0];
            REG_B_CNT_HI: rdata = cnt_b[CNT_W-1:BYTE_W];
            REG_SPARE:    rdata = '0;
            REG_CTRL:     rdata = ctrl_q;
        endcase
    end

endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq_a,
    output logic              irq_b
);

    localparam int N_TMR = 2;

    tmr_strobe_t      stb_v   [N_TMR];
    logic [CNT_W-1:0] cnt_v   [N_TMR];
    logic [CNT_W-1:0] latch_v [N_TMR];
    logic             flag_v  [N_TMR];
    logic             free_mode;

    ivt_regif u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .cnt_a     (cnt_v[0]),
        .latch_a   (latch_v[0]),
        .cnt_b     (cnt_v[1]),
        .stb_a     (stb_v[0]),
        .stb_b     (stb_v[1]),
        .free_mode (free_mode),
        .rdata     (rdata)
    );

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        ivt_timer #(
            .ONE_SHOT_ONLY (i != 0)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .free_mode (free_mode),
            .stb       (stb_v[i]),
            .wdata     (wdata),
            .cnt       (cnt_v[i]),
            .latch     (latch_v[i]),
            .flag      (flag_v[i])
        );
    end

    assign irq_a = flag_v[0];
    assign irq_b = flag_v[1];

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
    import ivt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wdata,
    input logic              irq_a,
    input logic              irq_b,
    input logic              free_a,
    input logic [CNT_W-1:0]  cnt_a,
    input logic [CNT_W-1:0]  cnt_b,
    input logic [CNT_W-1:0]  latch_a,
    input logic [CNT_W-1:0]  latch_b
);

    logic hi_a, hi_b;
    assign hi_a = wr_en && addr == REG_A_CNT_HI;
    assign hi_b = wr_en && addr == REG_B_CNT_HI;

    AST_RELOAD_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tick && free_a && !hi_a && cnt_a == '1 |=> cnt_a == $past(latch_a)); // R1

    AST_A_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a) |-> cnt_a == '0); // R2

    AST_B_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_b) |-> cnt_b == '0); // R2

    AST_LO_WRITE_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == REG_A_CNT_LO && !tick |=> cnt_a == $past(cnt_a)); // R3

    AST_A_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hi_a |=> cnt_a == {$past(wdata), $past(latch_a[BYTE_W-1:0])} && !irq_a); // R4

    AST_B_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        hi_b |=> cnt_b == {$past(wdata), $past(latch_b[BYTE_W-1:0])} && !irq_b); // R4

    AST_LAT_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == REG_A_LAT_HI && !tick |=>
            !irq_a && cnt_a == $past(cnt_a) && latch_a[CNT_W-1:BYTE_W] == $past(wdata)); // R5

    AST_RD_LO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == REG_A_CNT_LO && !tick |=> !irq_a); // R6

    AST_ZERO_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        tick && free_a && !hi_a && cnt_a == CNT_W'(1) |=> irq_a); // R10

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !hi_a |=> cnt_a == $past(cnt_a)); // R12

endmodule

bind ivt_top ivt_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq_a   (irq_a),
    .irq_b   (irq_b),
    .free_a  (free_mode),
    .cnt_a   (cnt_v[0]),
    .cnt_b   (cnt_v[1]),
    .latch_a (latch_v[0]),
    .latch_b (latch_v[1])
);

// File: tb/sim_ivt_top.sv
module sim_ivt_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_a, irq_b;

    always #5 clk = ~clk;

    ivt_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
    );

    typedef struct {
        int         sel;   // 0 rdata, 1 irq_a, 2 irq_b
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic push(int sel, logic [7:0] exp, string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // monitor: compares queued expectations 2 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                item_t      it;
                logic [7:0] act;
                it = q.pop_front();
                case (it.sel)
                    0:       act = rdata;
                    1:       act = {7'b0, irq_a};
                    default: act = {7'b0, irq_b};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: sel %0d actual %02h expected %02h",
                             it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic drive(bit we, bit re, logic [2:0] a, logic [7:0] d, bit tk);
        wr_en = we; rd_en = re; addr = a; wdata = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        drive(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic ticks(int n);
        repeat (n) drive(1'b0, 1'b0, addr, 8'h00, 1'b1);
    endtask

    task automatic chk_rd(logic [2:0] a, logic [7:0] exp, string req);
        addr = a;
        push(0, exp, req);
        @(negedge clk);
    endtask

    task automatic rd_side(logic [2:0] a, logic [7:0] exp, bit tk, string req);
        wr_en = 1'b0; rd_en = 1'b1; addr = a; tick = tk;
        push(0, exp, req);
        @(negedge clk);
        rd_en = 1'b0; tick = 1'b0;
    endtask

    task automatic chk_irq(int sel, bit exp, string req);
        push(sel, {7'b0, exp}, req);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk_rd(3'd0, 8'hFF, "R8"); chk_rd(3'd1, 8'hFF, "R8");
        chk_rd(3'd2, 8'hFF, "R8"); chk_rd(3'd3, 8'hFF, "R8");
        chk_rd(3'd4, 8'hFF, "R8"); chk_rd(3'd5, 8'hFF, "R8");
        chk_rd(3'd7, 8'h00, "R8");
        chk_rd(3'd6, 8'h00, "R7");
        chk_irq(1, 1'b0, "R8"); chk_irq(2, 1'b0, "R8");

        // low byte writes touch only the latch
        wr(3'd2, 8'h07); chk_rd(3'd2, 8'h07, "R3");
        wr(3'd0, 8'h04); chk_rd(3'd2, 8'h04, "R3"); chk_rd(3'd0, 8'hFF, "R3");

        // latch high write
        wr(3'd3, 8'h00); chk_rd(3'd3, 8'h00, "R5"); chk_rd(3'd1, 8'hFF, "R5");
        chk_irq(1, 1'b0, "R5");

        // free-running mode
        wr(3'd7, 8'h01); chk_rd(3'd7, 8'h01, "R11");
        wr(3'd1, 8'h00);
        chk_rd(3'd0, 8'h04, "R4"); chk_rd(3'd1, 8'h00, "R4");
        ticks(3); chk_irq(1, 1'b0, "R2"); chk_rd(3'd0, 8'h01, "R2");
        ticks(1); chk_irq(1, 1'b1, "R2"); chk_rd(3'd0, 8'h00, "R2");
        ticks(1); chk_rd(3'd0, 8'hFF, "R1"); chk_rd(3'd1, 8'hFF, "R1");
        ticks(1); chk_rd(3'd0, 8'h04, "R1");
        rd_side(3'd0, 8'h04, 1'b0, "R6"); chk_irq(1, 1'b0, "R6");
        ticks(3); chk_irq(1, 1'b0, "R1");
        ticks(1); chk_irq(1, 1'b1, "R1");
        rd_side(3'd1, 8'h00, 1'b0, "R6"); chk_irq(1, 1'b1, "R6");
        repeat (5) @(negedge clk);
        chk_rd(3'd0, 8'h00, "R12");

        // zero tick against flag-clearing read
        rd_side(3'd0, 8'h00, 1'b0, "R6"); chk_irq(1, 1'b0, "R6");
        ticks(5); chk_irq(1, 1'b0, "R10");
        rd_side(3'd0, 8'h01, 1'b1, "R10"); chk_irq(1, 1'b1, "R10");
        chk_rd(3'd0, 8'h00, "R10");

        // zero tick against latch high write
        wr(3'd3, 8'h00); chk_irq(1, 1'b0, "R5"); chk_rd(3'd0, 8'h00, "R5");
        ticks(5);
        drive(1'b1, 1'b0, 3'd3, 8'h00, 1'b1); chk_irq(1, 1'b1, "R10");

        // counter high write with tick: tick discarded
        drive(1'b1, 1'b0, 3'd1, 8'h00, 1'b1);
        chk_irq(1, 1'b0, "R4"); chk_rd(3'd0, 8'h04, "R4");

        // single-shot on both timers
        wr(3'd7, 8'h00); chk_rd(3'd7, 8'h00, "R11");
        wr(3'd4, 8'h02); wr(3'd5, 8'h00);
        chk_rd(3'd4, 8'h02, "R4"); chk_rd(3'd5, 8'h00, "R4");
        wr(3'd1, 8'h00);
        ticks(2); chk_irq(2, 1'b1, "R9"); chk_irq(1, 1'b0, "R9");
        ticks(2); chk_irq(1, 1'b1, "R9");
        chk_rd(3'd4, 8'hFE, "R9"); chk_rd(3'd5, 8'hFF, "R9");
        rd_side(3'd0, 8'h00, 1'b0, "R6");
        rd_side(3'd4, 8'hFE, 1'b0, "R6");
        ticks(65536);
        chk_irq(1, 1'b0, "R9"); chk_irq(2, 1'b0, "R9");
        chk_rd(3'd0, 8'h00, "R9"); chk_rd(3'd1, 8'h00, "R9");
        chk_rd(3'd4, 8'hFE, "R9");

        // timer B ignores the free-running bit
        wr(3'd7, 8'h01); chk_rd(3'd7, 8'h01, "R11");
        wr(3'd5, 8'h00); chk_irq(2, 1'b0, "R4");
        ticks(2); chk_irq(2, 1'b1, "R11");
        ticks(2); chk_rd(3'd4, 8'hFE, "R11"); chk_rd(3'd5, 8'hFF, "R11");

        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule